// File: doc/BRIEF.md
# Interval Timer with Watchdog and Oscillator Settle Delay

This block contains one 8-bit up-counter that does three jobs. A free-running prescaler divides the system clock by a power of two, and a 3-bit rate field picks the divisor. Each divided tick advances the counter. When the counter wraps from 0xFF to 0x00, it is an overflow.

After reset, or after a wake pulse from stop mode, the first overflow marks the end of the oscillator settle time. The block raises `settled`, and the CPU waits on that signal before it runs. Once `settled` is high, each overflow sets a sticky interval interrupt flag and advances a 3-bit watchdog stage. Eight overflows with no kick produce a one-cycle watchdog reset pulse.

Software can disable the watchdog only by writing one exact key byte. Any other key value enables it.

Top module: `interval_wdt`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises: `count` is 0, `settled` is 0, `tick_irq` is 0 and `wdt_reset` is 0. After reset the watchdog is enabled and the rate field holds RST_SEL (default 2).
- R2: With rate field value s, the counter advances once every 2^s clock cycles. Just after a restart, the first advance comes on the 2^s-th edge.
- R3: A write with `mode_wr` high applies `mode_data[2:0]` as the rate field. If `mode_data[3]` is 1, the write also clears the counter and the prescaler on that edge. If `mode_data[3]` is 0, the counter keeps counting with no break.
- R4: After reset or a `stop_wake` pulse, `settled` stays low until the first overflow, which comes 256·2^s cycles after the restart. It then rises and stays high until the next `stop_wake`.
- R5: An overflow while `settled` is high sets `tick_irq`. The flag holds until `irq_clr`, and a new overflow takes priority over a clear in the same cycle. An overflow while `settled` is low does not set it.
- R6: A `key_wr` with `key_data` equal to 0x5A disables the watchdog and zeroes its stage. A write of any other value enables it.
- R7: While enabled, the watchdog stage counts overflows that happen while `settled` is high. The 8th such overflow since the stage was last zeroed drives `wdt_reset` high for exactly one cycle, and counting starts again.
- R8: A `wdt_kick` pulse zeroes the watchdog stage, so the next reset pulse needs 8 more overflows.
- R9: A `stop_wake` pulse clears the counter and the prescaler on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | 4 | Bit 3 = restart, bits 2:0 = rate select |
| key_wr | input | 1 | Watchdog key write strobe |
| key_data | input | 8 | Watchdog key byte |
| wdt_kick | input | 1 | Watchdog clear strobe |
| stop_wake | input | 1 | Stop-mode release pulse, restarts settling |
| irq_clr | input | 1 | Clears the interval interrupt flag |
| count | output | 8 | Current counter value |
| tick_irq | output | 1 | Interval interrupt request flag |
| wdt_reset | output | 1 | One-cycle watchdog reset pulse |
| settled | output | 1 | Oscillator settle interval has ended |

## Verification
The bench measures the exact edge on which `settled` rises, and it also checks the edge before. A design with an off-by-one prescaler tap, or one that never restarts settling on wake, would release the CPU early or late.

It counts watchdog pulses across windows timed to the overflow. This catches a stage of the wrong length, a pulse that lasts more than one cycle, a kick that does not zero the stage, and a key compare that disables on the wrong byte.

It also checks that the overflow which ends settling sets no interrupt. It checks that a mode write without the restart bit leaves the count running with no break.

// File: rtl/interval_wdt.sv
module interval_wdt #(
  parameter int CNT_W   = 8,
  parameter int SEL_W   = 3,
  parameter int WD_W    = 3,
  parameter int KEY_W   = 8,
  parameter logic [KEY_W-1:0] OFF_KEY = 8'h5A,
  parameter int RST_SEL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [SEL_W:0]   mode_data,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             wdt_kick,
  input  logic             stop_wake,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic             tick_irq,
  output logic             wdt_reset,
  output logic             settled
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre, mask;
  logic [SEL_W-1:0] sel;
  logic [WD_W-1:0]  wd;
  logic             wd_en;

  wire restart  = stop_wake | (mode_wr & mode_data[SEL_W]);
  wire key_off  = key_wr & (key_data == OFF_KEY);
  wire tick     = &(pre | ~mask);
  wire ovf      = tick & (&count) & ~restart;
  wire live_ovf = ovf & settled;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < int'(sel)) mask[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      count <= '0;
      sel   <= SEL_W'(RST_SEL);
    end else begin
      pre <= restart ? '0 : pre + 1'b1;
      if (restart)   count <= '0;
      else if (tick) count <= count + 1'b1;
      if (mode_wr)   sel <= mode_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settled  <= 1'b0;
      tick_irq <= 1'b0;
    end else begin
      if (stop_wake) settled <= 1'b0;
      else if (ovf)  settled <= 1'b1;
      if (live_ovf)     tick_irq <= 1'b1;
      else if (irq_clr) tick_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en     <= 1'b1;
      wd        <= '0;
      wdt_reset <= 1'b0;
    end else begin
      if (key_wr) wd_en <= ~key_off;
      if (key_off || !wd_en || wdt_kick) wd <= '0;
      else if (live_ovf)                 wd <= wd + 1'b1;
      wdt_reset <= live_ovf & wd_en & (&wd) & ~wdt_kick & ~key_off;
    end
  end

  // R7
  wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);
  // R6
  wdt_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> $past(wd_en));
  // R9
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wake |=> (!settled && count == '0));
  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_data[SEL_W]) |=> (count == '0));
  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_irq) |-> (settled && $past(settled) && count == '0));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> (count == '0 || count == CNT_W'($past(count) + 1'b1)));
endmodule

// File: tb/interval_wdt_test.sv
`timescale 1ns/1ps
module interval_wdt_test;
  logic       clk = 0, rst_n = 0;
  logic       mode_wr = 0, key_wr = 0, wdt_kick = 0, stop_wake = 0, irq_clr = 0;
  logic [3:0] mode_data = '0;
  logic [7:0] key_data = '0;
  logic [7:0] count;
  logic       tick_irq, wdt_reset, settled;
  int checks = 0, errors = 0, pulses = 0;

  interval_wdt uut (.clk, .rst_n, .mode_wr, .mode_data, .key_wr, .key_data,
    .wdt_kick, .stop_wake, .irq_clr, .count, .tick_irq, .wdt_reset, .settled);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (wdt_reset) pulses++;
    end
  endtask

  task automatic wr_mode(input logic [3:0] d);
    mode_wr = 1; mode_data = d; run(1); mode_wr = 0;
  endtask

  task automatic wr_key(input logic [7:0] d);
    key_wr = 1; key_data = d; run(1); key_wr = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 count in reset", count, 0);
    chk("R1 settled in reset", settled, 0);
    chk("R1 irq in reset", tick_irq, 0);
    @(negedge clk); rst_n = 1;
    run(1);
    chk("R1 count after reset", count, 0);
    chk("R1 wdt_reset after reset", wdt_reset, 0);
  endtask

  task automatic t_settle_reset;
    run(1022);
    chk("R4 settled before end", settled, 0);
    chk("R2 default rate count", count, 255);
    run(1);
    chk("R4 settled at 1024 cycles", settled, 1);
    chk("R5 no irq from settling overflow", tick_irq, 0);
    chk("R4 count wrapped", count, 0);
  endtask

  task automatic t_rate;
    wr_mode(4'b1000);
    chk("R3 restart clears count", count, 0);
    run(10);
    chk("R2 rate 0 count", count, 10);
    wr_mode(4'b0000);
    chk("R3 no-restart write keeps counting", count, 11);
    wr_mode(4'b1011);
    chk("R3 restart with rate 3", count, 0);
    run(39);
    chk("R2 rate 3 before tick", count, 4);
    run(1);
    chk("R2 rate 3 count", count, 5);
  endtask

  task automatic t_irq;
    irq_clr = 1; run(1); irq_clr = 0;
    wr_mode(4'b1000);
    run(255);
    chk("R5 no irq before overflow", tick_irq, 0);
    chk("R5 count at top", count, 255);
    run(1);
    chk("R5 irq on overflow", tick_irq, 1);
    run(5);
    chk("R5 irq sticky", tick_irq, 1);
    irq_clr = 1; run(1); irq_clr = 0;
    chk("R5 irq cleared", tick_irq, 0);
  endtask

  task automatic t_wdt_fire;
    wr_key(8'h5A);
    wr_key(8'h00);
    wr_mode(4'b1000);
    pulses = 0;
    run(2047);
    chk("R7 no pulse before 8th overflow", pulses, 0);
    run(1);
    chk("R7 pulse on 8th overflow", wdt_reset, 1);
    run(1);
    chk("R7 pulse one cycle", wdt_reset, 0);
    chk("R7 single pulse", pulses, 1);
  endtask

  task automatic t_wdt_off;
    wr_key(8'h5A);
    wr_mode(4'b1000);
    pulses = 0;
    run(2100);
    chk("R6 disabled watchdog silent", pulses, 0);
    wr_key(8'hA5);
    wr_mode(4'b1000);
    pulses = 0;
    run(2048);
    chk("R6 other key enables", pulses, 1);
  endtask

  task automatic t_kick;
    wr_key(8'h5A);
    wr_key(8'h00);
    wr_mode(4'b1000);
    pulses = 0;
    run(1500);
    wdt_kick = 1; run(1); wdt_kick = 0;
    run(1826);
    chk("R8 kick delays pulse", pulses, 0);
    run(1);
    chk("R8 pulse 8 overflows after kick", wdt_reset, 1);
  endtask

  task automatic t_wake;
    irq_clr = 1; run(1); irq_clr = 0;
    run(37);
    stop_wake = 1; run(1); stop_wake = 0;
    chk("R9 wake clears count", count, 0);
    chk("R4 wake drops settled", settled, 0);
    run(255);
    chk("R4 still settling", settled, 0);
    run(1);
    chk("R4 settled after wake", settled, 1);
    chk("R5 no irq from wake settling", tick_irq, 0);
  endtask

  initial begin
    t_reset();
    t_settle_reset();
    t_rate();
    t_irq();
    t_wdt_fire();
    t_wdt_off();
    t_kick();
    t_wake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule